// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Control

This block is a synthesizable behavioural model of a small one-time-programmable byte memory. It holds its own storage array and decodes four control levels into an operating mode: an active-low chip select, an active-low read enable, a flag that says the programming supply is present, and a flag that says one chosen address line is held at an identifier voltage. From that mode it either drives a stored byte onto the data bus, floats the bus, takes a programming pulse, or returns an identifier byte. The analog conditions are reduced to digital flags. The tri-state bus is split into a data output, a data input and an output-enable strobe.

Programming can only clear bits. While a programming pulse is active, the block captures the address and the data. When the pulse ends, the captured data is ANDed into the stored word. An erase request returns every word to all ones. It does this by sweeping the array one word per clock, and it raises a completion flag at the end of the sweep. Every output is registered: a change on the inputs shows up on the outputs one clock later.

Top module: `otp_mode_ctrl`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. After an erase completes, every word reads as all ones.
- R2: With cs_n=0 and re_n=0, one clock later data_oe=1 and data_o carries the word at addr, unless the identifier read of R9 applies.
- R3: With cs_n=1 and vpp_on=0, one clock later data_oe=0 and data_o=0, for either level of re_n.
- R4: With cs_n=0, re_n=1 and vpp_on=0, one clock later data_oe=0. No word changes.
- R5: With vpp_on=1, cs_n=0 and re_n=1, the block is in program mode: the bus is not driven, and addr and data_i are captured on every clock. On the first clock after program mode ends, the captured word is written as old AND captured data.
- R6: With vpp_on=1, cs_n=1 and re_n=0, one clock later data_oe=1 and data_o carries the stored word at addr.
- R7: With vpp_on=1, cs_n=1 and re_n=1, one clock later data_oe=0, and the array is not written.
- R8: Programming never turns a stored 0 into a 1. Repeating the same pulse leaves the word unchanged.
- R9: With cs_n=0, re_n=0, id_hv=1, and every address bit other than bit 0 and bit ID_BIT at 0, the block returns an identifier byte. addr[0]=0 gives 8'h01 and addr[0]=1 gives 8'h10. The level of addr[ID_BIT] does not matter.
- R10: With id_hv=1 but any other address bit (not bit 0, not bit ID_BIT) at 1, a read returns the array word.
- R11: Every identifier byte has odd parity, and bit DATA_W-1 is the parity bit.
- R12: An erase_req seen while idle starts a sweep that writes one word per clock for 2**ADDR_W clocks. An erase_req seen during a sweep is ignored. During the sweep the bus is not driven and program mode cannot be entered. erase_done goes low when a sweep starts, goes high on the clock that writes the last word, and stays high until the next sweep starts.
- R13: While rst_n=0, data_oe=0, data_o=0 and erase_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| cs_n | input | 1 | Active-low chip select |
| re_n | input | 1 | Active-low read enable (output gate) |
| vpp_on | input | 1 | Programming supply present |
| id_hv | input | 1 | Identifier voltage present on address bit ID_BIT |
| addr | input | ADDR_W | Word address |
| data_i | input | DATA_W | Bus data in, used when programming |
| data_o | output | DATA_W | Bus data out, zero when not driven |
| data_oe | output | 1 | Bus output enable |
| erase_req | input | 1 | Start an erase sweep |
| erase_done | output | 1 | Erase sweep finished |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=8 and ID_BIT=4. With a 64-word array, a full erase sweep takes 64 clocks, so the bench can repeat whole sweeps, check that every word reads back as all ones, and time the moment erase_done rises exactly. Moving the identifier line to bit 4 of the narrow address lets the bench set one other address bit while id_hv is high, and check that the block falls back to an array read. It also toggles the identifier line's own address bit, which must be ignored.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_OUT_OFF,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT,
        MD_ID_READ,
        MD_ERASING
    } otp_mode_e;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int ID_BIT = 9
) (
    input  logic              cs_n,
    input  logic              re_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output otp_mode_e         mode
);

    logic rest_low;

    // Every address bit except bit 0 and the identifier line must be low.
    always_comb begin
        rest_low = 1'b1;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i != 0 && i != ID_BIT && addr[i]) begin
                rest_low = 1'b0;
            end
        end
    end

    always_comb begin
        if (busy) begin
            mode = MD_ERASING;
        end else if (cs_n) begin
            if (vpp_on && !re_n) begin
                mode = MD_VERIFY;
            end else if (vpp_on) begin
                mode = MD_INHIBIT;
            end else begin
                mode = MD_STANDBY;
            end
        end else if (re_n) begin
            mode = vpp_on ? MD_PROGRAM : MD_OUT_OFF;
        end else if (id_hv && rest_low) begin
            mode = MD_ID_READ;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-2:0] MFR_BITS = 'h01,
    parameter logic [DATA_W-2:0] DEV_BITS = 'h10
) (
    input  logic              sel_dev,
    output logic [DATA_W-1:0] id_byte
);

    // The top bit is chosen so that the whole byte has an odd count of ones.
    localparam logic [DATA_W-1:0] MFR_BYTE = {~(^MFR_BITS), MFR_BITS};
    localparam logic [DATA_W-1:0] DEV_BYTE = {~(^DEV_BITS), DEV_BITS};

    assign id_byte = sel_dev ? DEV_BYTE : MFR_BYTE;

endmodule

// File: rtl/otp_erase_seq.sv
module otp_erase_seq #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              busy,
    output logic [ADDR_W-1:0] idx,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ADDR_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (seq_q.idx == LAST_IDX) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end else if (req) begin
            seq_d.busy = 1'b1;
            seq_d.done = 1'b0;
            seq_d.idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = seq_q.busy;
    assign idx  = seq_q.idx;
    assign done = seq_q.done;

endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int ID_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              re_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    input  logic              erase_req,
    output logic              erase_done
);

    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] dout;
        logic              prog;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    otp_mode_e         mode;
    logic              erase_busy;
    logic [ADDR_W-1:0] erase_idx;
    logic [DATA_W-1:0] id_byte;
    logic [DATA_W-1:0] arr_rd_a;
    logic [DATA_W-1:0] arr_rd_b;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [DATA_W-1:0] arr_wdata;
    logic              commit;

    otp_mode_decode #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_decode (
        .cs_n   (cs_n),
        .re_n   (re_n),
        .vpp_on (vpp_on),
        .id_hv  (id_hv),
        .addr   (addr),
        .busy   (erase_busy),
        .mode   (mode)
    );

    otp_id_rom #(.DATA_W(DATA_W)) u_id (
        .sel_dev (addr[0]),
        .id_byte (id_byte)
    );

    otp_erase_seq #(.ADDR_W(ADDR_W)) u_erase (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (erase_req),
        .busy  (erase_busy),
        .idx   (erase_idx),
        .done  (erase_done)
    );

    otp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .we      (arr_we),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr_a (addr),
        .rdata_a (arr_rd_a),
        .raddr_b (ctl_q.paddr),
        .rdata_b (arr_rd_b)
    );

    // A pulse completes on the first cycle that is no longer program mode.
    assign commit = ctl_q.prog && (mode != MD_PROGRAM) && !erase_busy;

    always_comb begin
        arr_we    = erase_busy || commit;
        arr_waddr = erase_busy ? erase_idx : ctl_q.paddr;
        arr_wdata = erase_busy ? ERASED : (arr_rd_b & ctl_q.pdata);
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.oe   = 1'b0;
        ctl_d.dout = '0;
        ctl_d.prog = 1'b0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                ctl_d.oe   = 1'b1;
                ctl_d.dout = arr_rd_a;
            end
            MD_ID_READ: begin
                ctl_d.oe   = 1'b1;
                ctl_d.dout = id_byte;
            end
            MD_PROGRAM: begin
                ctl_d.prog  = 1'b1;
                ctl_d.paddr = addr;
                ctl_d.pdata = data_i;
            end
            MD_STANDBY, MD_OUT_OFF, MD_INHIBIT, MD_ERASING: begin
                ctl_d.oe = 1'b0;
            end
            default: begin
                ctl_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign data_o  = ctl_q.dout;
    assign data_oe = ctl_q.oe;

endmodule

// File: rtl/otp_mode_ctrl_chk.sv
module otp_mode_ctrl_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int ID_BIT = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              re_n,
    input logic              vpp_on,
    input logic              id_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe,
    input logic              erase_req,
    input logic              erase_done,
    input logic              busy,
    input logic              we,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] old
);

    logic id_sel;

    always_comb begin
        id_sel = id_hv;
        for (int i = 1; i < ADDR_W; i++) begin
            if (i != ID_BIT && addr[i]) begin
                id_sel = 1'b0;
            end
        end
    end

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !re_n && !busy) |=> data_oe);                        // R2

    AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !vpp_on) |=> (!data_oe && data_o == '0));             // R3

    AST_DISABLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && re_n) |=> !data_oe);                                 // R4

    AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !re_n && vpp_on && !busy) |=> data_oe);               // R6

    AST_INHIBIT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && re_n && vpp_on) |=> !data_oe);                        // R7

    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !busy) |-> ((wdata & ~old) == '0));                     // R8

    AST_ID_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !re_n && id_sel && !busy) |=> (^data_o));            // R11

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && !erase_req) |=> erase_done);                    // R12

    AST_ERASE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !data_oe);                                            // R12

endmodule

bind otp_mode_ctrl otp_mode_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_BIT (ID_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .re_n       (re_n),
    .vpp_on     (vpp_on),
    .id_hv      (id_hv),
    .addr       (addr),
    .data_o     (data_o),
    .data_oe    (data_oe),
    .erase_req  (erase_req),
    .erase_done (erase_done),
    .busy       (erase_busy),
    .we         (arr_we),
    .wdata      (arr_wdata),
    .old        (arr_rd_b)
);

// File: tb/tb_otp_mode_ctrl.sv
module tb_otp_mode_ctrl;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int IDB   = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          re_n = 1'b1;
    logic          vpp_on = 1'b0;
    logic          id_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_i = '0;
    logic [DW-1:0] data_o;
    logic          data_oe;
    logic          erase_req = 1'b0;
    logic          erase_done;

    always #5 clk = ~clk;

    otp_mode_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ID_BIT(IDB)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .re_n       (re_n),
        .vpp_on     (vpp_on),
        .id_hv      (id_hv),
        .addr       (addr),
        .data_i     (data_i),
        .data_o     (data_o),
        .data_oe    (data_oe),
        .erase_req  (erase_req),
        .erase_done (erase_done)
    );

    // Behavioural reference state
    logic [DW-1:0] m_mem [DEPTH];
    logic          e_oe, e_done;
    logic [DW-1:0] e_d;
    bit            m_busy, m_prog, m_drv, m_pnow, m_idsel;
    int            m_idx;
    logic [AW-1:0] m_pa;
    logic [DW-1:0] m_pd, m_val;

    int    compared = 0;
    int    mismatched = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string phase = "R13";

    always @(posedge clk) begin
        if (!rst_n) begin
            e_oe = 1'b0; e_d = '0; e_done = 1'b0;
            m_busy = 1'b0; m_prog = 1'b0; m_idx = 0;
        end else begin
            m_idsel = id_hv;
            for (int i = 1; i < AW; i++) if (i != IDB && addr[i]) m_idsel = 1'b0;
            m_drv = 1'b0; m_pnow = 1'b0; m_val = '0;
            if (!m_busy) begin
                if (!cs_n && !re_n) begin
                    m_drv = 1'b1;
                    m_val = m_idsel ? (addr[0] ? 8'h10 : 8'h01) : m_mem[addr];
                end else if (cs_n && !re_n && vpp_on) begin
                    m_drv = 1'b1;
                    m_val = m_mem[addr];
                end else if (!cs_n && re_n && vpp_on) begin
                    m_pnow = 1'b1;
                end
            end
            e_oe = m_drv;
            e_d  = m_drv ? m_val : '0;
            if (m_busy) begin
                m_mem[m_idx] = '1;
                if (m_idx == DEPTH - 1) begin
                    m_busy = 1'b0; e_done = 1'b1;
                end else begin
                    m_idx++;
                end
            end else begin
                if (m_prog && !m_pnow) m_mem[m_pa] = m_mem[m_pa] & m_pd;
                if (erase_req) begin
                    m_busy = 1'b1; m_idx = 0; e_done = 1'b0;
                end
            end
            m_prog = m_pnow;
            if (m_pnow) begin
                m_pa = addr; m_pd = data_i;
            end
        end
    end

    always @(negedge clk) begin
        if (checking && !finished) begin
            compared++;
            if (data_oe !== e_oe || data_o !== e_d || erase_done !== e_done) begin
                mismatched++;
                $display("FAIL %s: oe/data/done actual %b/%h/%b expected %b/%h/%b",
                         phase, data_oe, data_o, erase_done, e_oe, e_d, e_done);
            end
        end
    end

    task automatic drive(input logic c, input logic r, input logic v, input logic h,
                         input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
        cs_n = c; re_n = r; vpp_on = v; id_hv = h; addr = a; data_i = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_erase(input int extra_req_at);
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        for (int k = 0; k < DEPTH + 3; k++) begin
            erase_req = (k == extra_req_at);
            @(negedge clk);
        end
        erase_req = 1'b0;
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(1'b0, 1'b1, 1'b1, 1'b0, a, d, 3);
        drive(1'b1, 1'b1, 1'b1, 1'b0, a, 8'h00, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        checking = 1'b1;
        phase = "R13";
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R12";
        do_erase(20);
        phase = "R1";
        for (int a = 0; a < DEPTH; a += 9) drive(1'b0, 1'b0, 1'b0, 1'b0, AW'(a), 8'h00, 1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, AW'(DEPTH - 1), 8'h00, 1);

        phase = "R5";
        pulse(6'd5, 8'hA5);
        phase = "R2";
        drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00, 2);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd6, 8'h00, 1);
        phase = "R8";
        pulse(6'd5, 8'hA5);
        pulse(6'd5, 8'h5A);
        pulse(6'd5, 8'hFF);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00, 2);
        phase = "R5";
        pulse(6'd40, 8'h3C);
        pulse(6'd41, 8'hC3);
        phase = "R6";
        drive(1'b1, 1'b0, 1'b1, 1'b0, 6'd40, 8'h00, 2);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 6'd41, 8'h00, 2);
        phase = "R7";
        drive(1'b1, 1'b1, 1'b1, 1'b0, 6'd40, 8'h00, 3);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd40, 8'h00, 2);
        phase = "R3";
        drive(1'b1, 1'b0, 1'b0, 1'b0, 6'd40, 8'h00, 2);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd41, 8'h00, 2);
        phase = "R4";
        drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd41, 8'h00, 3);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd41, 8'h00, 2);

        phase = "R9";
        drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 8'h00, 2);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 8'h00, 2);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd17, 8'h00, 2);
        phase = "R11";
        drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd16, 8'h00, 2);
        phase = "R10";
        drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd41, 8'h00, 2);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd4, 8'h00, 2);

        phase = "R12";
        erase_req = 1'b1;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd7, 8'h00, 1);
        erase_req = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd7, 8'h00, 10);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 6'd7, 8'h00, DEPTH);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 2);
        phase = "R1";
        for (int a = 0; a < DEPTH; a += 5) drive(1'b0, 1'b0, 1'b0, 1'b0, AW'(a), 8'h00, 1);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 8'h00, 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule